// File: doc/BRIEF.md
# Peripheral-to-Memory DMA Channel

This block is one DMA channel that moves data from a peripheral's receive register into memory. A block transfer is made of one or more microblocks of equal length. Each microblock is fetched from the peripheral in chunks and written to memory in bursts. A hardware request from the peripheral starts one chunk, and a software trigger does the same. Every read of a chunk goes to the same fixed peripheral address. The data read is always staged in an internal FIFO. As soon as a chunk leaves at least one burst's worth of items in the FIFO, the channel writes that burst to memory with incrementing addresses. At the end of a microblock, any remainder is flushed as a shorter burst.

The controller is a single state machine with six states:
- `ST_IDLE`: waits for `cfg_en`, then latches the configuration and moves to `ST_WAIT_REQ`.
- `ST_WAIT_REQ`: waits for a pending request and moves to `ST_READ` when one is present.
- `ST_READ`: issues one peripheral read per cycle until the chunk is complete, then moves to `ST_DECIDE`.
- `ST_DECIDE`: chooses the next step.
  - It moves to `ST_WRITE` when a full burst is buffered, or when the microblock has ended with items still left.
  - Otherwise it moves back to `ST_WAIT_REQ` (reloading the microblock counter if the microblock has just ended), or to `ST_DONE` after the last microblock.
- `ST_WRITE`: sends one burst and returns to `ST_DECIDE` on the final beat.
- `ST_DONE`: lasts one cycle and returns to `ST_IDLE`.

Top module: `p2m_dma_channel`

## Requirements
- R1: A pulse on `per_req` or `sw_req` while the channel is busy makes it read one chunk. Requests that arrive while it is idle are discarded, and no peripheral read happens without a request.
- R2: `cfg_chunk_sel` selects the chunk size: 0→1, 1→2, 2→4, 3→8, and 4 or above→16 items per request.
- R3: Every read drives `per_rd_addr` with the address latched from `cfg_per_addr` and never increments it, so every item of a chunk carries the value the register held during that chunk.
- R4: Read data (valid one cycle after `per_rd_en`) passes through the internal FIFO. No memory write beat is presented in a cycle in which a peripheral read is issued.
- R5: `cfg_burst_sel` selects the burst length: 0→1, 1→4, 2→8, 3→16. After each chunk, a burst of exactly that length is written while the FIFO holds at least that many items. `mem_wr_last` marks the final beat of each burst.
- R6: When the microblock length is not a multiple of the chunk size, the final chunk of each microblock reads only the remaining items.
- R7: When a microblock ends with fewer items buffered than a burst, those items are written as one shorter burst before the next microblock starts.
- R8: The first beat of a block goes to `cfg_mem_addr`. Each following beat's address is DW/8 bytes higher, and this continues across bursts and microblocks.
- R9: A request that arrives while a chunk is being read is held and served once that chunk completes.
- R10: After the last microblock has been written, `done` is high for exactly one cycle and `busy` then falls. A `cfg_en` pulse while busy has no effect on the running transfer.
- R11: While `mem_wr_valid` is high and `mem_wr_ready` is low, address, data and valid hold steady.
- R12: A block is `cfg_ublk_cnt` microblocks of `cfg_ublk_len` items each. Both values must be nonzero. Every microblock needs fresh requests for its chunks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Start pulse, accepted only when idle |
| cfg_chunk_sel | input | 3 | Chunk size code |
| cfg_burst_sel | input | 2 | Memory burst length code |
| cfg_ublk_len | input | LEN_W | Items per microblock |
| cfg_ublk_cnt | input | CNT_W | Microblocks per block |
| cfg_per_addr | input | AW | Peripheral receive register address |
| cfg_mem_addr | input | AW | Memory start byte address |
| per_req | input | 1 | Hardware chunk request pulse |
| sw_req | input | 1 | Software chunk trigger pulse |
| per_rd_en | output | 1 | Peripheral read strobe |
| per_rd_addr | output | AW | Peripheral read address |
| per_rd_data | input | DW | Read data, valid the cycle after the strobe |
| mem_wr_valid | output | 1 | Memory write beat valid |
| mem_wr_ready | input | 1 | Memory accepts the beat |
| mem_wr_addr | output | AW | Byte address of the beat |
| mem_wr_data | output | DW | Beat data |
| mem_wr_last | output | 1 | Final beat of a burst |
| busy | output | 1 | Channel active |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets four groups of cases:
- A 16-item chunk feeding 4-item bursts, where the FIFO must drain several bursts after a single chunk.
- Microblock lengths that leave a trailing partial chunk and a short flush burst. A design that ignored the tail would over-read the peripheral, and one without the flush would hang or mix the next microblock into the burst.
- Requests issued in the middle of a chunk. A design that dropped them would stall until the watchdog fires.
- Write backpressure combined with a re-enable pulse during a transfer. A faulty design would change address or data mid-stall or restart its address sequence.

// File: rtl/p2m_pkg.sv
package p2m_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_REQ,
        ST_READ,
        ST_DECIDE,
        ST_WRITE,
        ST_DONE
    } p2m_state_t;

    localparam int SZ_W = 5;

    function automatic logic [SZ_W-1:0] chunk_items(input logic [2:0] sel);
        unique case (sel)
            3'd0:    return SZ_W'(1);
            3'd1:    return SZ_W'(2);
            3'd2:    return SZ_W'(4);
            3'd3:    return SZ_W'(8);
            default: return SZ_W'(16);
        endcase
    endfunction

    function automatic logic [SZ_W-1:0] burst_items(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return SZ_W'(1);
            2'd1:    return SZ_W'(4);
            2'd2:    return SZ_W'(8);
            default: return SZ_W'(16);
        endcase
    endfunction

endpackage

// File: rtl/p2m_fifo.sv
module p2m_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head
);
    localparam int PW = $clog2(DEPTH);

    logic [DW-1:0] store [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    assign head = store[rd_ptr];

endmodule

// File: rtl/p2m_req_latch.sv
module p2m_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic hw_req,
    input  logic sw_req,
    input  logic take,
    output logic pending
);
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                pend_q <= 1'b0;
        else if (!arm)             pend_q <= 1'b0;
        else if (hw_req || sw_req) pend_q <= 1'b1;
        else if (take)             pend_q <= 1'b0;
    end

    assign pending = pend_q;

endmodule

// File: rtl/p2m_addr_step.sv
module p2m_addr_step #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    addr_q <= '0;
        else if (load) addr_q <= load_addr;
        else if (step) addr_q <= addr_q + AW'(STEP);
    end

    assign addr = addr_q;

endmodule

// File: rtl/p2m_dma_channel.sv
module p2m_dma_channel
    import p2m_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int LEN_W      = 16,
    parameter int CNT_W      = 8,
    parameter int FIFO_DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic [2:0]       cfg_chunk_sel,
    input  logic [1:0]       cfg_burst_sel,
    input  logic [LEN_W-1:0] cfg_ublk_len,
    input  logic [CNT_W-1:0] cfg_ublk_cnt,
    input  logic [AW-1:0]    cfg_per_addr,
    input  logic [AW-1:0]    cfg_mem_addr,
    input  logic             per_req,
    input  logic             sw_req,
    output logic             per_rd_en,
    output logic [AW-1:0]    per_rd_addr,
    input  logic [DW-1:0]    per_rd_data,
    output logic             mem_wr_valid,
    input  logic             mem_wr_ready,
    output logic [AW-1:0]    mem_wr_addr,
    output logic [DW-1:0]    mem_wr_data,
    output logic             mem_wr_last,
    output logic             busy,
    output logic             done
);
    localparam int BYTES  = DW / 8;
    localparam int FILL_W = $clog2(FIFO_DEPTH) + 1;

    p2m_state_t state_q, state_d;

    logic [SZ_W-1:0]   chunk_sz_q, burst_sz_q;
    logic [SZ_W-1:0]   chunk_left_q, beats_left_q;
    logic [LEN_W-1:0]  ublk_len_q, ublk_left_q;
    logic [CNT_W-1:0]  ublks_rem_q;
    logic [FILL_W-1:0] fill_q;
    logic [AW-1:0]     per_addr_q;
    logic              rd_q;

    logic              pending, take, start, hs;
    logic              burst_ready, ublk_end, last_ublk, flush_now;
    logic [SZ_W-1:0]   chunk_first, burst_first;

    assign start       = (state_q == ST_IDLE) && cfg_en;
    assign take        = (state_q == ST_WAIT_REQ) && pending;
    assign hs          = mem_wr_valid && mem_wr_ready;
    assign burst_ready = fill_q >= FILL_W'(burst_sz_q);
    assign ublk_end    = (ublk_left_q == '0);
    assign last_ublk   = (ublks_rem_q == CNT_W'(1));
    assign flush_now   = burst_ready || (ublk_end && (fill_q != '0));
    assign chunk_first = (ublk_left_q < LEN_W'(chunk_sz_q)) ? ublk_left_q[SZ_W-1:0] : chunk_sz_q;
    assign burst_first = burst_ready ? burst_sz_q : fill_q[SZ_W-1:0];

    p2m_req_latch u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (state_q != ST_IDLE),
        .hw_req  (per_req),
        .sw_req  (sw_req),
        .take    (take),
        .pending (pending)
    );

    p2m_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rd_q),
        .push_data (per_rd_data),
        .pop       (hs),
        .head      (mem_wr_data)
    );

    p2m_addr_step #(.AW(AW), .STEP(BYTES)) u_waddr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_addr (cfg_mem_addr),
        .step      (hs),
        .addr      (mem_wr_addr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (cfg_en) state_d = ST_WAIT_REQ;
            ST_WAIT_REQ: if (pending) state_d = ST_READ;
            ST_READ:     if (chunk_left_q == SZ_W'(1)) state_d = ST_DECIDE;
            ST_DECIDE: begin
                if (flush_now)                  state_d = ST_WRITE;
                else if (ublk_end && last_ublk) state_d = ST_DONE;
                else                            state_d = ST_WAIT_REQ;
            end
            ST_WRITE:    if (hs && beats_left_q == SZ_W'(1)) state_d = ST_DECIDE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        per_rd_en    = (state_q == ST_READ);
        per_rd_addr  = per_addr_q;
        mem_wr_valid = (state_q == ST_WRITE);
        mem_wr_last  = (state_q == ST_WRITE) && (beats_left_q == SZ_W'(1));
        busy         = (state_q != ST_IDLE);
        done         = (state_q == ST_DONE);
    end

    // Counters and latched configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chunk_sz_q   <= '0;
            burst_sz_q   <= '0;
            chunk_left_q <= '0;
            beats_left_q <= '0;
            ublk_len_q   <= '0;
            ublk_left_q  <= '0;
            ublks_rem_q  <= '0;
            fill_q       <= '0;
            per_addr_q   <= '0;
            rd_q         <= 1'b0;
        end else begin
            rd_q <= (state_q == ST_READ);
            unique case (state_q)
                ST_IDLE: if (cfg_en) begin
                    chunk_sz_q  <= chunk_items(cfg_chunk_sel);
                    burst_sz_q  <= burst_items(cfg_burst_sel);
                    ublk_len_q  <= cfg_ublk_len;
                    ublk_left_q <= cfg_ublk_len;
                    ublks_rem_q <= cfg_ublk_cnt;
                    per_addr_q  <= cfg_per_addr;
                    fill_q      <= '0;
                end
                ST_WAIT_REQ: if (pending) chunk_left_q <= chunk_first;
                ST_READ: begin
                    chunk_left_q <= chunk_left_q - 1'b1;
                    ublk_left_q  <= ublk_left_q - 1'b1;
                    fill_q       <= fill_q + 1'b1;
                end
                ST_DECIDE: begin
                    if (flush_now) begin
                        beats_left_q <= burst_first;
                    end else if (ublk_end && !last_ublk) begin
                        ublk_left_q <= ublk_len_q;
                        ublks_rem_q <= ublks_rem_q - 1'b1;
                    end
                end
                ST_WRITE: if (hs) begin
                    beats_left_q <= beats_left_q - 1'b1;
                    fill_q       <= fill_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/p2m_dma_channel_chk.sv
module p2m_dma_channel_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          per_rd_en,
    input logic [AW-1:0] per_rd_addr,
    input logic          mem_wr_valid,
    input logic          mem_wr_ready,
    input logic [AW-1:0] mem_wr_addr,
    input logic [DW-1:0] mem_wr_data,
    input logic          mem_wr_last,
    input logic          busy,
    input logic          done
);
    localparam int BYTES     = DW / 8;
    localparam int MAX_BURST = 16;

    logic          hs;
    logic [5:0]    beat_cnt;
    logic [AW-1:0] last_addr;
    logic          have_last;

    assign hs = mem_wr_valid && mem_wr_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_cnt  <= '0;
            last_addr <= '0;
            have_last <= 1'b0;
        end else begin
            if (hs) beat_cnt <= mem_wr_last ? 6'd0 : beat_cnt + 6'd1;
            if (!busy) begin
                have_last <= 1'b0;
            end else if (hs) begin
                have_last <= 1'b1;
                last_addr <= mem_wr_addr;
            end
        end
    end

    assert_rd_only_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        per_rd_en |-> busy);

    assert_fixed_rd_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (per_rd_en && $past(per_rd_en)) |-> $stable(per_rd_addr));

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        per_rd_en |-> !mem_wr_valid);

    assert_burst_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && mem_wr_last) |-> (32'(beat_cnt) + 1 <= MAX_BURST));

    assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && have_last) |-> (mem_wr_addr == last_addr + AW'(BYTES)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data) && $stable(mem_wr_last)));

endmodule

bind p2m_dma_channel p2m_dma_channel_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .per_rd_en    (per_rd_en),
    .per_rd_addr  (per_rd_addr),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_last  (mem_wr_last),
    .busy         (busy),
    .done         (done)
);

// File: tb/p2m_dma_channel_test.sv
`timescale 1ns/1ps
module p2m_dma_channel_test;
    localparam int AW = 32, DW = 32, LEN_W = 16, CNT_W = 8, BYTES = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_en = 1'b0;
    logic [2:0]       cfg_chunk_sel = '0;
    logic [1:0]       cfg_burst_sel = '0;
    logic [LEN_W-1:0] cfg_ublk_len = '0;
    logic [CNT_W-1:0] cfg_ublk_cnt = '0;
    logic [AW-1:0]    cfg_per_addr = '0;
    logic [AW-1:0]    cfg_mem_addr = '0;
    logic             per_req = 1'b0;
    logic             sw_req = 1'b0;
    logic             per_rd_en;
    logic [AW-1:0]    per_rd_addr;
    logic [DW-1:0]    per_rd_data = '0;
    logic             mem_wr_valid;
    logic             mem_wr_ready = 1'b1;
    logic [AW-1:0]    mem_wr_addr;
    logic [DW-1:0]    mem_wr_data;
    logic             mem_wr_last;
    logic             busy;
    logic             done;

    p2m_dma_channel uut (.*);

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    logic [AW+DW-1:0] exp_q [$];
    int               exp_burst_q [$];
    logic [DW-1:0]    per_reg = '0;
    logic [AW-1:0]    exp_per_addr = '0;
    bit               stall = 1'b0;
    int               cyc = 0, beats = 0, done_seen = 0, reads_seen = 0;
    bit               held = 1'b0;
    logic [AW+DW-1:0] held_val;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Peripheral model: read data returned one cycle after the strobe
    always @(posedge clk) if (per_rd_en) per_rd_data <= per_reg;

    // Ready pattern and monitor (ready set first, then the pending handshake sampled)
    always @(negedge clk) begin
        cyc++;
        mem_wr_ready = stall ? ((cyc % 3) != 0) : 1'b1;
        if (rst_n) begin
            if (held) begin
                check(mem_wr_valid && ({mem_wr_addr, mem_wr_data} == held_val), "R11",
                      "stalled beat changed", {mem_wr_addr, mem_wr_data}, held_val);
                held = 1'b0;
            end
            if (per_rd_en) begin
                reads_seen++;
                check(!mem_wr_valid, "R4", "write beat during read", 64'(mem_wr_valid), 64'd0);
            end
            if (done) done_seen++;
            if (mem_wr_valid && !mem_wr_ready) begin
                held = 1'b1;
                held_val = {mem_wr_addr, mem_wr_data};
            end
            if (mem_wr_valid && mem_wr_ready) begin
                beats++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R12", "unexpected beat", 64'(mem_wr_addr), 64'd0);
                end else begin
                    logic [AW+DW-1:0] e;
                    e = exp_q.pop_front();
                    check(mem_wr_addr == e[AW+DW-1:DW], "R8", "beat address",
                          64'(mem_wr_addr), 64'(e[AW+DW-1:DW]));
                    check(mem_wr_data == e[DW-1:0], "R3", "beat data",
                          64'(mem_wr_data), 64'(e[DW-1:0]));
                end
                if (mem_wr_last) begin
                    if (exp_burst_q.size() == 0) begin
                        check(1'b0, "R5", "unexpected burst end", 64'(beats), 64'd0);
                    end else begin
                        int eb;
                        eb = exp_burst_q.pop_front();
                        check(beats == eb, (eb < (1 << cfg_burst_sel)) ? "R7" : "R5",
                              "burst length", 64'(beats), 64'(eb));
                    end
                    beats = 0;
                end
            end
        end
    end

    function automatic int csize(input logic [2:0] s);
        return (s >= 3'd4) ? 16 : (1 << s);
    endfunction

    function automatic int bsize(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (2 << s);
    endfunction

    task automatic wait_reads(input int n);
        int cnt = 0;
        while (cnt < n) begin
            @(negedge clk);
            if (per_rd_en) begin
                cnt++;
                check(per_rd_addr == exp_per_addr, "R3", "peripheral address",
                      64'(per_rd_addr), 64'(exp_per_addr));
            end
        end
    endtask

    task automatic push_items(inout logic [AW-1:0] addr, input int k, input logic [DW-1:0] v);
        for (int i = 0; i < k; i++) begin
            exp_q.push_back({addr, v});
            addr += AW'(BYTES);
        end
    endtask

    // mode 0: hardware requests, 1: software triggers plus a re-enable poke, 2: requests in pairs
    task automatic run_block(input logic [2:0] csel, input logic [1:0] bsel, input int L,
                             input int N, input int mode, input bit stl);
        int c, b, fill, left, k, k1, k2, cnt, start_reads, start_done;
        logic [AW-1:0] addr;
        logic [DW-1:0] val;
        c = csize(csel);
        b = bsize(bsel);
        for (int u = 0; u < N; u++) begin
            left = L; fill = 0;
            while (left > 0) begin
                k = (left < c) ? left : c;
                left -= k; fill += k;
                while (fill >= b) begin exp_burst_q.push_back(b); fill -= b; end
            end
            if (fill > 0) exp_burst_q.push_back(fill);
        end
        stall = stl;
        @(negedge clk);
        cfg_chunk_sel = csel; cfg_burst_sel = bsel;
        cfg_ublk_len = LEN_W'(L); cfg_ublk_cnt = CNT_W'(N);
        cfg_per_addr = 32'h4000_0000 + 32'(mode * 16); exp_per_addr = cfg_per_addr;
        cfg_mem_addr = 32'h2000_0000 + 32'(mode * 32'h1000);
        addr = cfg_mem_addr;
        start_reads = reads_seen; start_done = done_seen;
        cfg_en = 1'b1;
        @(negedge clk);
        cfg_en = 1'b0;
        cnt = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (per_rd_en) cnt++;
        end
        check(cnt == 0, "R1", "read without request", 64'(cnt), 64'd0);
        val = 32'hA000_0000 + 32'(mode << 16);
        for (int u = 0; u < N; u++) begin
            left = L;
            while (left > 0) begin
                val++;
                per_reg = val;
                if (mode == 2 && left > c) begin
                    k1 = c;
                    k2 = (left - c < c) ? left - c : c;
                    push_items(addr, k1 + k2, val);
                    per_req = 1'b1;
                    @(negedge clk);
                    per_req = 1'b0;
                    wait_reads(1);
                    per_req = 1'b1;
                    @(negedge clk);
                    cnt = per_rd_en ? 2 : 1;
                    per_req = 1'b0;
                    wait_reads(k1 + k2 - cnt);
                    left -= k1 + k2;
                end else begin
                    k = (left < c) ? left : c;
                    push_items(addr, k, val);
                    if (mode == 1) sw_req = 1'b1; else per_req = 1'b1;
                    @(negedge clk);
                    sw_req = 1'b0; per_req = 1'b0;
                    wait_reads(k);
                    left -= k;
                    if (mode == 1 && u == 0 && left > 0) begin
                        cfg_mem_addr = 32'hDEAD_0000;
                        cfg_en = 1'b1;
                        @(negedge clk);
                        cfg_en = 1'b0;
                    end
                end
                @(negedge clk);
            end
        end
        for (int t = 0; t < 3000 && done_seen == start_done; t++) @(negedge clk);
        check(done_seen == start_done + 1, "R10", "done pulses", 64'(done_seen - start_done), 64'd1);
        @(negedge clk);
        check(!busy && !done, "R10", "busy/done after completion", 64'({busy, done}), 64'd0);
        check(reads_seen - start_reads == N * L,
              (mode == 2) ? "R9" : ((L % c) != 0 ? "R6" : "R2"),
              "peripheral reads", 64'(reads_seen - start_reads), 64'(N * L));
        check(exp_q.size() == 0, "R12", "items left unwritten", 64'(exp_q.size()), 64'd0);
        check(exp_burst_q.size() == 0, "R7", "bursts left unwritten", 64'(exp_burst_q.size()), 64'd0);
        exp_q.delete();
        exp_burst_q.delete();
    endtask

    initial begin
        #(8 * 150000);
        check(1'b0, "R10", "watchdog expired", 64'd0, 64'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({per_rd_en, mem_wr_valid, busy, done} == 4'b0, "R10", "reset outputs",
              64'({per_rd_en, mem_wr_valid, busy, done}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        per_req = 1'b1;
        @(negedge clk);
        per_req = 1'b0;
        check(!busy && !per_rd_en, "R1", "request while idle", 64'({busy, per_rd_en}), 64'd0);
        run_block(3'd0, 2'd1, 8, 2, 0, 1'b0);
        run_block(3'd2, 2'd2, 10, 2, 1, 1'b1);
        run_block(3'd4, 2'd1, 20, 1, 0, 1'b1);
        run_block(3'd1, 2'd3, 7, 3, 2, 1'b1);
        run_block(3'd3, 2'd0, 8, 1, 2, 1'b0);
        run_block(3'd7, 2'd2, 5, 2, 0, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule